// File: doc/BRIEF.md
# Three-Byte Interrupt Status Aggregator

This block gathers 24 interrupt sources into three 8-bit sticky status bytes and drives one registered, active-high interrupt line to a host. A source sets its status bit on a rising edge of its input. The bit stays set until the host clears the status bytes. Each status byte has two mask registers. The capture mask decides whether a source edge is recorded at all. The line mask decides whether a recorded bit may raise the interrupt line.

The host reaches the block through a byte-wide register port built around an address pointer. The host loads the pointer, and every read-advance or write then moves it on by one. The three status bytes sit at consecutive addresses, so a host can collect all 24 bits in a single three-byte burst. Any byte write aimed at a status byte wipes all three status bytes at once, whatever the data. The mask bytes are plain read/write storage, so the host can change them with read-modify-write.

Top module: `irq_status_agg`

## Requirements
- R1: After reset every status bit is 0, every capture-mask and line-mask bit is 1, and `irq_o` is 0.
- R2: A rising edge on `src_i[n]`, when its capture-mask bit is 0, sets status bit n. Source n is held in status byte n/8 at address n/8, bit n%8. The bit stays set while the input is held or falls, until the next clear.
- R3: While capture-mask bit n is 1, an edge on `src_i[n]` leaves status bit n at 0.
- R4: `irq_o` goes to 1 one clock after some status bit is 1 while its line-mask bit is 0. In every other case it goes to 0 one clock later.
- R5: A write to address 0, 1 or 2 clears all 24 status bits. The value of `wdata_i` has no effect on this.
- R6: If an unmasked rising edge arrives in the same cycle as a clearing write, its status bit is set after that cycle.
- R7: Source 23 is reserved. Status byte 2 bit 7 always reads 0, even when the source toggles and is unmasked.
- R8: The capture masks sit at addresses 3 to 5 and the line masks at addresses 6 to 8, one byte per status byte, in the order byte 0, byte 1, byte 2. They read back what was written. Addresses 9 to 15 read as 0 and ignore writes.
- R9: `ptr_load_i` sets the pointer to `ptr_val_i`. Otherwise, `wr_en_i` or `rd_next_i` advances it by one, wrapping at 16. `rdata_o` always shows the register at the pointer.
- R10: A source held high after a clear is not captured again until it falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 24 | Interrupt source levels |
| ptr_load_i | input | 1 | Load the register pointer |
| ptr_val_i | input | 4 | Pointer value to load |
| wr_en_i | input | 1 | Write `wdata_i` at the pointer, then advance |
| wdata_i | input | 8 | Write data |
| rd_next_i | input | 1 | Advance the pointer after a read |
| rdata_o | output | 8 | Register at the current pointer |
| irq_o | output | 1 | Interrupt line, active high |

## Verification
The hazard to cover is a fresh source edge that lands in the same cycle as a clearing write to a status byte. The bench sets a pointer to a status address. Then, in a single cycle, it raises an unmasked source and asserts the write. The capture must survive the clear. A companion case holds that source high through a later clear and expects no recapture. The cycle-by-cycle reference model checks both cases, and so do directed reads of the status byte.

// File: rtl/irq_agg_pkg.sv
`timescale 1ns/1ps
package irq_agg_pkg;
  typedef enum logic [1:0] {REG_STS, REG_SMSK, REG_LMSK, REG_NONE} reg_kind_e;

  function automatic reg_kind_e kind_of(input int unsigned a, input int unsigned nb);
    if (a < nb)            return REG_STS;
    else if (a < 2 * nb)   return REG_SMSK;
    else if (a < 3 * nb)   return REG_LMSK;
    else                   return REG_NONE;
  endfunction

  function automatic int unsigned byte_of(input int unsigned a, input int unsigned nb);
    if (a < 3 * nb) return a % nb;
    else            return 0;
  endfunction
endpackage

// File: rtl/irq_agg_ptr.sv
`timescale 1ns/1ps
module irq_agg_ptr #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_q, ptr_d;
  logic          ptr_en;

  always_comb begin
    ptr_en = load_i | step_i;
    ptr_d  = load_i ? load_val_i : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/irq_agg_maskbank.sv
`timescale 1ns/1ps
module irq_agg_maskbank #(
  parameter int NBYTE = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NBYTE-1:0]   sel_i,
  input  logic [7:0]         wdata_i,
  output logic [NBYTE*8-1:0] mask_o
);
  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    logic [7:0] m_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        m_q <= 8'hFF;
      else if (sel_i[b]) m_q <= wdata_i;
    end
    assign mask_o[b*8 +: 8] = m_q;
  end
endmodule

// File: rtl/irq_agg_capture.sv
`timescale 1ns/1ps
module irq_agg_capture #(
  parameter int               NBYTE    = 3,
  parameter logic [NBYTE*8-1:0] RSV_BITS = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NBYTE*8-1:0] src_i,
  input  logic [NBYTE*8-1:0] smask_i,
  input  logic               clr_i,
  output logic [NBYTE*8-1:0] status_o,
  output logic [NBYTE*8-1:0] prev_o
);
  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    logic [7:0] sts_q, sts_d, prv_q, hit;
    always_comb begin
      hit   = src_i[b*8 +: 8] & ~prv_q & ~smask_i[b*8 +: 8] & ~RSV_BITS[b*8 +: 8];
      sts_d = (clr_i ? 8'h00 : sts_q) | hit;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sts_q <= 8'h00;
        prv_q <= 8'h00;
      end else begin
        sts_q <= sts_d;
        prv_q <= src_i[b*8 +: 8];
      end
    end
    assign status_o[b*8 +: 8] = sts_q;
    assign prev_o[b*8 +: 8]   = prv_q;
  end
endmodule

// File: rtl/irq_status_agg.sv
`timescale 1ns/1ps
module irq_status_agg
  import irq_agg_pkg::*;
#(
  parameter int                 NBYTE    = 3,
  parameter int                 AW       = 4,
  parameter logic [NBYTE*8-1:0] RSV_BITS = 24'h800000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NBYTE*8-1:0] src_i,
  input  logic               ptr_load_i,
  input  logic [AW-1:0]      ptr_val_i,
  input  logic               wr_en_i,
  input  logic [7:0]         wdata_i,
  input  logic               rd_next_i,
  output logic [7:0]         rdata_o,
  output logic               irq_o
);
  localparam int NBIT = NBYTE * 8;

  logic [AW-1:0]    ptr;
  logic [NBIT-1:0]  status, prev, smask, lmask;
  logic [NBYTE-1:0] smask_sel, lmask_sel;
  reg_kind_e        kind;
  int unsigned      sel_byte;
  logic             clr_all;
  logic             irq_q, irq_d;

  irq_agg_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load_i(ptr_load_i), .load_val_i(ptr_val_i),
    .step_i(wr_en_i | rd_next_i), .ptr_o(ptr)
  );

  always_comb begin
    kind     = kind_of(int'(ptr), NBYTE);
    sel_byte = byte_of(int'(ptr), NBYTE);
    clr_all  = wr_en_i && (kind == REG_STS);
  end

  for (genvar b = 0; b < NBYTE; b++) begin : g_sel
    assign smask_sel[b] = wr_en_i && (kind == REG_SMSK) && (sel_byte == b);
    assign lmask_sel[b] = wr_en_i && (kind == REG_LMSK) && (sel_byte == b);
  end

  irq_agg_maskbank #(.NBYTE(NBYTE)) u_smask (
    .clk(clk), .rst_n(rst_n), .sel_i(smask_sel), .wdata_i(wdata_i), .mask_o(smask)
  );

  irq_agg_maskbank #(.NBYTE(NBYTE)) u_lmask (
    .clk(clk), .rst_n(rst_n), .sel_i(lmask_sel), .wdata_i(wdata_i), .mask_o(lmask)
  );

  irq_agg_capture #(.NBYTE(NBYTE), .RSV_BITS(RSV_BITS)) u_cap (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .smask_i(smask), .clr_i(clr_all),
    .status_o(status), .prev_o(prev)
  );

  always_comb begin
    case (kind)
      REG_STS:  rdata_o = status[sel_byte*8 +: 8];
      REG_SMSK: rdata_o = smask[sel_byte*8 +: 8];
      REG_LMSK: rdata_o = lmask[sel_byte*8 +: 8];
      default:  rdata_o = 8'h00;
    endcase
  end

  always_comb irq_d = |(status & ~lmask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_agg_chk.sv
`timescale 1ns/1ps
module irq_agg_chk #(
  parameter int                 NBYTE    = 3,
  parameter int                 AW       = 4,
  parameter logic [NBYTE*8-1:0] RSV_BITS = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NBYTE*8-1:0] src_i,
  input logic               wr_en_i,
  input logic               ptr_load_i,
  input logic               rd_next_i,
  input logic [AW-1:0]      ptr,
  input logic [NBYTE*8-1:0] status,
  input logic [NBYTE*8-1:0] prev,
  input logic [NBYTE*8-1:0] smask,
  input logic [NBYTE*8-1:0] lmask,
  input logic               irq_o
);
  logic clr_w;
  assign clr_w = wr_en_i && (ptr < AW'(NBYTE));

  // R3
  smask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & $past(smask)) == '0));

  // R4
  line_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|(status & ~lmask)));

  // R5
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w && ((src_i & ~prev) == '0)) |=> (status == '0));

  // R6
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w && ((src_i & ~prev & ~smask & ~RSV_BITS) != '0)) |=> (status != '0));

  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status & RSV_BITS) == '0);

  // R9
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en_i || rd_next_i) && !ptr_load_i) |=> (ptr == AW'($past(ptr) + 1'b1)));
endmodule

bind irq_status_agg irq_agg_chk #(.NBYTE(NBYTE), .AW(AW), .RSV_BITS(RSV_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en_i(wr_en_i),
  .ptr_load_i(ptr_load_i), .rd_next_i(rd_next_i), .ptr(ptr),
  .status(status), .prev(prev), .smask(smask), .lmask(lmask), .irq_o(irq_o)
);

// File: tb/sim_irq_status_agg.sv
`timescale 1ns/1ps
module sim_irq_status_agg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] src;
  logic        ld, wr, nx;
  logic [3:0]  pv;
  logic [7:0]  wd;
  logic [7:0]  rdata;
  logic        irq;
  int          total = 0;
  int          bad = 0;

  always #2.5 clk = ~clk;

  irq_status_agg u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .ptr_load_i(ld), .ptr_val_i(pv),
    .wr_en_i(wr), .wdata_i(wd), .rd_next_i(nx), .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference model
  logic [7:0] m_sts [3];
  logic [7:0] m_smk [3];
  logic [7:0] m_lmk [3];
  logic [23:0] m_prev;
  int          m_ptr;
  logic        m_irq;

  function automatic logic [7:0] m_read(input int a);
    if (a < 3)      return m_sts[a];
    else if (a < 6) return m_smk[a-3];
    else if (a < 9) return m_lmk[a-6];
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_sts[i] = 8'h00; m_smk[i] = 8'hFF; m_lmk[i] = 8'hFF;
      end
      m_prev = '0; m_ptr = 0; m_irq = 1'b0;
    end else begin
      logic       pend;
      logic [7:0] nsts [3];
      pend = 1'b0;
      for (int i = 0; i < 3; i++) if ((m_sts[i] & ~m_lmk[i]) != 0) pend = 1'b1;
      for (int n = 0; n < 24; n++) begin
        nsts[n/8][n%8] = (wr && m_ptr < 3) ? 1'b0 : m_sts[n/8][n%8];
        if (n != 23 && src[n] && !m_prev[n] && !m_smk[n/8][n%8]) nsts[n/8][n%8] = 1'b1;
      end
      if (wr && m_ptr >= 3 && m_ptr < 6) m_smk[m_ptr-3] = wd;
      if (wr && m_ptr >= 6 && m_ptr < 9) m_lmk[m_ptr-6] = wd;
      for (int i = 0; i < 3; i++) m_sts[i] = nsts[i];
      m_prev = src;
      if (ld) m_ptr = int'(pv);
      else if (wr || nx) m_ptr = (m_ptr + 1) % 16;
      m_irq = pend;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison with the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 rdata vs model", int'(rdata), int'(m_read(m_ptr)));
      chk("R4 irq vs model", int'(irq), int'(m_irq));
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic setp(input int a);
    ld = 1'b1; pv = 4'(a); tick(); ld = 1'b0;
  endtask

  task automatic wrb(input logic [7:0] d);
    wr = 1'b1; wd = d; tick(); wr = 1'b0;
  endtask

  task automatic nxt();
    nx = 1'b1; tick(); nx = 1'b0;
  endtask

  task automatic pulse(input logic [23:0] bits);
    src = src | bits; tick(); src = src & ~bits; tick();
  endtask

  task automatic rdchk(input string tag, input int a, input int exp);
    setp(a); chk(tag, int'(rdata), exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src = '0; ld = 0; wr = 0; nx = 0; pv = '0; wd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R1 reset values
    chk("R1 irq", int'(irq), 0);
    for (int a = 0; a < 3; a++) rdchk("R1 status", a, 8'h00);
    for (int a = 3; a < 9; a++) rdchk("R1 masks", a, 8'hFF);
    rdchk("R8 unused", 12, 0);
    // R8 unmask all through a burst of writes
    setp(3);
    for (int i = 0; i < 6; i++) wrb(8'h00);
    rdchk("R8 smask0", 3, 0);
    rdchk("R8 lmask2", 8, 0);
    // R2 capture, burst read (R9)
    pulse(24'h020201);
    tick();
    setp(0);
    chk("R2 byte0", int'(rdata), 8'h01); nxt();
    chk("R2 byte1", int'(rdata), 8'h02); nxt();
    chk("R2 byte2", int'(rdata), 8'h02);
    chk("R4 irq high", int'(irq), 1);
    // R4 line mask hides pending bits
    setp(6); wrb(8'hFF); wrb(8'hFF); wrb(8'hFF);
    tick(); tick();
    chk("R4 irq masked", int'(irq), 0);
    setp(7); wrb(8'h00); tick(); tick();
    chk("R4 irq byte1", int'(irq), 1);
    // R5 clear via byte 1, data ignored
    setp(1); wrb(8'h5A); tick();
    rdchk("R5 byte0", 0, 0);
    rdchk("R5 byte1", 1, 0);
    rdchk("R5 byte2", 2, 0);
    chk("R5 irq", int'(irq), 0);
    // R3 capture mask
    setp(4); wrb(8'hFF);
    pulse(24'h000300);
    rdchk("R3 byte1", 1, 0);
    // R7 reserved source
    pulse(24'h800000);
    rdchk("R7 byte2", 2, 0);
    pulse(24'h400000);
    rdchk("R7 byte2 neighbour", 2, 8'h40);
    setp(0); wrb(8'h00);
    // R6 edge in the clear cycle
    setp(0);
    src[0] = 1'b1; wr = 1'b1; wd = 8'h00; tick(); wr = 1'b0;
    rdchk("R6 byte0", 0, 8'h01);
    rdchk("R6 byte2", 2, 0);
    // R10 held level not recaptured
    setp(0); wrb(8'hFF); tick(); tick();
    rdchk("R10 byte0", 0, 0);
    src[0] = 1'b0; tick();
    // R8 unused address write ignored
    setp(9); wrb(8'h00);
    rdchk("R8 unused after write", 9, 0);
    rdchk("R8 smask2 kept", 5, 8'h00);
    // R9 pointer wraps at 16
    setp(15); nxt();
    chk("R9 wrap", int'(rdata), 0);
    tick();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule